// File: doc/BRIEF.md
# Programmable Priority Bus Arbiter

This block decides which of eight masters owns a shared local bus. The priority order is set by software: eight 4-bit priority slots each name a master index, and the arbiter walks the slots from slot 0 (highest) to slot 7 and grants the first named master that is requesting. A slot holding a value above 7 names nobody. A master that no slot names can only get the bus by being parked.

When nobody is requesting, the bus is parked on a master chosen by a control field. Parking codes 0 to 3 select masters 0 to 3. Any other code parks nobody, and all grants drop.

A granted master keeps the bus for as long as it holds its request. A second output grants the data bus after a transfer-start strobe. It does so in the same cycle as the strobe, or at the earliest one cycle later, depending on a delay bit in the control register. Software reaches the slots and the control bits through a small word-addressed register port.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, word 0 reads 0x01230000, word 1 reads 0x45670000 and word 2 reads 0x02000000. While reset is held, addr_gnt and data_gnt are 0.
- R2: Bits [31-4k:28-4k] of word 0 hold slot k, and the same bits of word 1 hold slot 4+k (k = 0..3). Bits [15:0] of words 0 and 1 read 0. In word 2, bit 29 is the delay bit and bits [27:24] are the parking code; all its other bits read 0. Word 3 reads 0 and ignores writes. cfg_rdata follows cfg_addr in the same cycle.
- R3: When no grant is being held, the next addr_gnt (one clock later) is one-hot on the master named by the lowest-numbered slot whose master is requesting.
- R4: Slots holding 8..15 are skipped. A master named in no slot is never granted while requesting, other than through parking.
- R5: addr_gnt is at most one-hot. While the granted master keeps its request, addr_gnt stays unchanged. Re-arbitration happens at the first clock edge that samples the request low.
- R6: With no requests and no grant held, the next addr_gnt is one-hot on master c for parking code c in 0..3, and all zero for codes 4..15.
- R7: With the delay bit at 0, data_gnt is high in the same cycle as xfer_start when dbus_busy is low.
- R8: With the delay bit at 1, data_gnt is never high in the cycle of xfer_start. It rises in the first later cycle with dbus_busy low. Only one transfer is outstanding at a time, and data_gnt is never high while dbus_busy is high.
- R9: A register write never changes a grant being held. New slot, parking and delay values apply from the clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Bus request, one bit per master |
| xfer_start | input | 1 | Transfer-start strobe from the owning master |
| dbus_busy | input | 1 | Data bus is occupied |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| addr_gnt | output | 8 | One-hot address-bus grant |
| data_gnt | output | 1 | Data-bus grant |

## Verification
The results fall due at different times, and the bench checks each one in its own cycle. addr_gnt comes from a register, so it is checked one clock after the requests and the register contents that decided it. data_gnt and cfg_rdata are combinational, so they are checked in the same cycle their inputs are driven. A register write is modelled as taking effect at the edge that latches it, after that edge's arbitration has already used the old values. Inputs change at the falling edge, and every output is sampled just before the next change.

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int NM    = 8,
  parameter int NS    = 8,
  parameter int SW    = 4,
  parameter int NPARK = 4,
  parameter int AW    = 2,
  parameter int DW    = 32,
  parameter int PARK_RST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic          xfer_start,
  input  logic          dbus_busy,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic [NM-1:0] addr_gnt,
  output logic          data_gnt
);
  localparam int IW      = $clog2(NM);
  localparam int SPR     = NS / 2;
  localparam int DLY_BIT = DW - 3;
  localparam int PARK_HI = DW - 5;

  logic [SW-1:0] slot_q [NS];
  logic [SW-1:0] park_q;
  logic          dly_q;
  logic [NM-1:0] gnt_q;
  logic          pend_q;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        slot_q[s] <= SW'(s);
      else if (cfg_wr && cfg_addr == AW'(s / SPR))
        slot_q[s] <= cfg_wdata[DW-1-SW*(s%SPR) -: SW];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      park_q <= SW'(PARK_RST);
      dly_q  <= 1'b0;
    end else if (cfg_wr && cfg_addr == AW'(2)) begin
      park_q <= cfg_wdata[PARK_HI -: SW];
      dly_q  <= cfg_wdata[DLY_BIT];
    end

  logic [DW-1:0] prio_rd [2];
  logic [DW-1:0] ctrl_rd;

  always_comb begin
    prio_rd[0] = '0;
    prio_rd[1] = '0;
    for (int s = 0; s < NS; s++)
      prio_rd[s/SPR][DW-1-SW*(s%SPR) -: SW] = slot_q[s];
    ctrl_rd = '0;
    ctrl_rd[DLY_BIT] = dly_q;
    ctrl_rd[PARK_HI -: SW] = park_q;
  end

  always_comb
    case (cfg_addr)
      AW'(0):  cfg_rdata = prio_rd[0];
      AW'(1):  cfg_rdata = prio_rd[1];
      AW'(2):  cfg_rdata = ctrl_rd;
      default: cfg_rdata = '0;
    endcase

  logic          win_found;
  logic [IW-1:0] win_idx;

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    for (int s = 0; s < NS; s++)
      if (!win_found && int'(slot_q[s]) < NM && req[slot_q[s][IW-1:0]]) begin
        win_found = 1'b1;
        win_idx   = slot_q[s][IW-1:0];
      end
  end

  wire           hold    = |(gnt_q & req);
  wire           park_ok = int'(park_q) < NPARK;
  wire  [NM-1:0] win_oh  = NM'(1) << win_idx;
  wire  [NM-1:0] park_oh = park_ok ? NM'(1) << park_q[IW-1:0] : '0;
  wire  [NM-1:0] gnt_d   = hold ? gnt_q : (win_found ? win_oh : park_oh);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;

  assign addr_gnt = gnt_q;

  assign data_gnt = !dbus_busy && (pend_q || (xfer_start && !dly_q));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q || xfer_start) && !data_gnt;
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int NM    = 8,
  parameter int SW    = 4,
  parameter int NPARK = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] req,
  input logic [NM-1:0] addr_gnt,
  input logic          data_gnt,
  input logic          xfer_start,
  input logic          dbus_busy,
  input logic          dly,
  input logic          pend,
  input logic [SW-1:0] park
);
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_gnt));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|(addr_gnt & req)) |=> addr_gnt == $past(addr_gnt));

  a_r6_reserved_park: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && int'(park) >= NPARK) |=> addr_gnt == '0);

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    data_gnt |-> !dbus_busy);

  a_r8_not_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (dly && xfer_start && !pend) |-> !data_gnt);

  a_r7_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!dly && xfer_start && !dbus_busy) |-> data_gnt);
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.NM(NM), .SW(SW), .NPARK(NPARK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .addr_gnt(addr_gnt),
  .data_gnt(data_gnt), .xfer_start(xfer_start), .dbus_busy(dbus_busy),
  .dly(dly_q), .pend(pend_q), .park(park_q)
);

// File: tb/sim_prio_bus_arbiter.sv
module sim_prio_bus_arbiter;
  localparam time PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic        xfer_start = 1'b0;
  logic        dbus_busy = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  addr_gnt;
  logic        data_gnt;

  always #(PERIOD/2) clk = ~clk;

  prio_bus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_start(xfer_start),
    .dbus_busy(dbus_busy), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr_gnt(addr_gnt),
    .data_gnt(data_gnt)
  );

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  logic [3:0] mslot [8];
  logic [3:0] mpark;
  logic       mdly;
  logic [7:0] mgnt;
  logic       mpend;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {mslot[0], mslot[1], mslot[2], mslot[3], 16'h0};
      2'd1: return {mslot[4], mslot[5], mslot[6], mslot[7], 16'h0};
      2'd2: return {2'b00, mdly, 1'b0, mpark, 24'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] exp_next(input logic [7:0] r);
    if ((mgnt & r) != 0) return mgnt;
    for (int s = 0; s < 8; s++)
      if (mslot[s] < 8 && r[mslot[s][2:0]]) return 8'(1) << mslot[s][2:0];
    if (mpark < 4) return 8'(1) << mpark[2:0];
    return 8'h0;
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [31:0] d);
    case (a)
      2'd0: begin mslot[0]=d[31:28]; mslot[1]=d[27:24]; mslot[2]=d[23:20]; mslot[3]=d[19:16]; end
      2'd1: begin mslot[4]=d[31:28]; mslot[5]=d[27:24]; mslot[6]=d[23:20]; mslot[7]=d[19:16]; end
      2'd2: begin mdly=d[29]; mpark=d[27:24]; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [7:0] r, input logic xs, input logic busy,
                      input logic wr, input logic [1:0] a, input logic [31:0] d,
                      input string tg);
    logic [7:0] nxt;
    logic       dg;
    string      t;
    req = r; xfer_start = xs; dbus_busy = busy;
    cfg_wr = wr; cfg_addr = a; cfg_wdata = d;
    #1;
    dg = !busy && (mpend || (xs && !mdly));
    chk(mdly ? "R8 data_gnt" : "R7 data_gnt", 32'(data_gnt), 32'(dg));
    chk("R2 cfg_rdata", cfg_rdata, exp_read(a));
    nxt = exp_next(r);
    if (tg != "") t = tg;
    else if ((mgnt & r) != 0) t = "R5 hold";
    else if (r == 0) t = "R6 park";
    else t = "R3 priority";
    @(posedge clk);
    mgnt  = nxt;
    mpend = (mpend || xs) && !dg;
    if (wr) model_write(a, d);
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(t, 32'(addr_gnt), 32'(nxt));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 8; s++) mslot[s] = 4'(s);
    mpark = 4'd2; mdly = 1'b0; mgnt = '0; mpend = 1'b0;

    repeat (3) @(negedge clk);
    chk("R1 addr_gnt in reset", 32'(addr_gnt), 32'h0);
    chk("R1 data_gnt in reset", 32'(data_gnt), 32'h0);
    cfg_addr = 2'd0; #1 chk("R1 word0", cfg_rdata, 32'h01230000);
    cfg_addr = 2'd1; #1 chk("R1 word1", cfg_rdata, 32'h45670000);
    cfg_addr = 2'd2; #1 chk("R1 word2", cfg_rdata, 32'h02000000);
    cfg_addr = 2'd3; #1 chk("R2 word3", cfg_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    step(8'h00, 0, 0, 0, 2'd0, 0, "R6 park reset code");
    step(8'h30, 0, 0, 0, 2'd0, 0, "R3 identity order");
    step(8'h30, 0, 0, 0, 2'd0, 0, "R5 hold");
    step(8'h20, 0, 0, 0, 2'd0, 0, "R5 release");
    step(8'h20, 0, 0, 1, 2'd0, 32'h7000_0000, "R9 held during write");
    step(8'h00, 0, 0, 1, 2'd2, 32'h0F00_0000, "R6 park");
    step(8'h00, 0, 0, 0, 2'd2, 0, "R6 reserved park");
    step(8'h00, 0, 0, 1, 2'd3, 32'hFFFF_FFFF, "R2 word3 write");
    step(8'h00, 0, 0, 1, 2'd0, 32'h8F76_FFFF, "R6 reserved park");
    step(8'h00, 0, 0, 1, 2'd1, 32'h0000_FFFF, "R2 reserved write");
    step(8'h41, 0, 0, 0, 2'd0, 0, "R4 skip invalid slots");
    step(8'h00, 0, 0, 0, 2'd1, 0, "R6 reserved park");
    step(8'h3E, 0, 0, 0, 2'd0, 0, "R4 unlisted master");
    step(8'h00, 1, 0, 0, 2'd2, 0, "R7 same cycle");
    step(8'h00, 1, 1, 0, 2'd2, 0, "R7 busy");
    step(8'h00, 0, 0, 1, 2'd2, 32'h2000_0000, "R8 write delay");
    step(8'h00, 1, 0, 0, 2'd2, 0, "R8 strobe");
    step(8'h00, 0, 1, 0, 2'd2, 0, "R8 busy wait");
    step(8'h00, 0, 0, 0, 2'd2, 0, "R8 granted");
    step(8'h00, 1, 0, 0, 2'd2, 0, "R8 strobe");
    step(8'h00, 0, 0, 0, 2'd2, 0, "R8 granted");

    r = 8'h00;
    for (int i = 0; i < 4000; i++) begin
      logic        wr;
      logic [1:0]  a;
      logic [31:0] d;
      if ($urandom % 4 == 0) r = r ^ 8'($urandom & $urandom);
      wr = ($urandom % 12 == 0);
      a  = 2'($urandom);
      d  = $urandom;
      step(r, !mpend && ($urandom % 5 == 0), ($urandom % 3 == 0), wr, a, d, "");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule